// File: doc/BRIEF.md
# Trap Target Privilege Selector

This block picks the privilege level that will handle a trap in a core with machine mode always present. Supervisor mode, user mode and user-level trap handling are each optional. A trap request arrives as a one-cycle strobe. It carries the following:

- the current privilege level;
- whether the trap is an interrupt or a synchronous exception;
- whether it is a non-maskable interrupt;
- the cause code;
- the four delegation vectors: machine and supervisor, each for interrupts and for exceptions;
- three configuration bits saying which optional modes exist.

One cycle later the block presents the chosen level with a single-cycle valid pulse. The chosen level stays on the output until the next request.

The delegation rules follow the usual two-stage scheme. When a needed optional mode is missing, delegation falls back to a lower level or back to machine mode, so that a trap never lands in a mode that does not exist. Saving the program counter, recording the cause, computing the vector and updating status bits are left to the surrounding trap logic.

Top module: `trap_target_sel`

## Requirements
- R1: While rst_ni is low and after its release, tgt_valid_o is 0 and tgt_priv_o is machine (2'b11). Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R2: A request sampled at a clock edge makes tgt_valid_o 1 during the following cycle only. A cycle with no request is followed by tgt_valid_o 0.
- R3: A request with is_nmi_i set targets machine, whatever the delegation vectors, the current level or the configuration bits are.
- R4: A request taken in machine mode (cur_priv_i 2'b11) targets machine.
- R5: If the current level is not machine, the machine delegation bit at index cause_i is clear, and the second-level rule of R8 does not apply, the target is machine.
- R6: If the current level is not machine, the machine delegation bit at index cause_i is set, and supervisor mode is present (has_s_i), the target is supervisor, unless R8 applies.
- R7: If machine delegation applies and supervisor mode is absent, the target is user when user-level trap support is usable, and machine otherwise. The target is never supervisor while has_s_i is 0.
- R8: When the current level is user (2'b00), supervisor mode and usable user-level trap support are both present, and the supervisor delegation bit at index cause_i is set, the target is user.
- R9: Interrupts (is_intr_i 1) index mideleg_i and sideleg_i. Exceptions (is_intr_i 0) index medeleg_i and sedeleg_i. The vector pair not selected has no effect on the result.
- R10: A cause_i value not below DELEG_W is treated as not delegated at both levels.
- R11: User-level trap support is usable only when both has_n_i and has_u_i are 1. If has_n_i is 1 while has_u_i is 0, the result is the same as with has_n_i at 0.
- R12: tgt_priv_o keeps its value in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Trap request strobe |
| is_intr_i | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| is_nmi_i | input | 1 | Non-maskable interrupt |
| cur_priv_i | input | 2 | Privilege level when the trap is taken |
| cause_i | input | CAUSE_W | Cause code, used as the delegation bit index |
| mideleg_i | input | DELEG_W | Machine interrupt delegation vector |
| sideleg_i | input | DELEG_W | Supervisor interrupt delegation vector |
| medeleg_i | input | DELEG_W | Machine exception delegation vector |
| sedeleg_i | input | DELEG_W | Supervisor exception delegation vector |
| has_s_i | input | 1 | Supervisor mode present |
| has_u_i | input | 1 | User mode present |
| has_n_i | input | 1 | User-level trap support present |
| tgt_priv_o | output | 2 | Target privilege level |
| tgt_valid_o | output | 1 | One-cycle pulse when tgt_priv_o is new |

## Verification
The checker assumes that cur_priv_i never carries the reserved code 2'b10 while a request is raised. It states this as a property of its own. The bench only ever drives the three legal codes. The checker also assumes that the request and trap fields are sampled together at the same edge, and the bench changes them only at the falling edge. The out-of-range cause rule needs a vector narrower than the cause index space, so the bench adds a second instance with 16-bit vectors. That instance sees the low bits of the same stimulus.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;
endpackage

// File: rtl/deleg_bit_pick.sv
module deleg_bit_pick #(
  parameter int CAUSE_W = 6,
  parameter int DELEG_W = 64
) (
  input  logic [DELEG_W-1:0] vec_i,
  input  logic [CAUSE_W-1:0] idx_i,
  output logic               bit_o
);
  localparam int SPAN = 1 << CAUSE_W;

  // Widen to the full index space; positions past DELEG_W read as 0.
  logic [SPAN-1:0] ext;
  for (genvar i = 0; i < SPAN; i++) begin : g_ext
    if (i < DELEG_W) begin : g_in
      assign ext[i] = vec_i[i];
    end else begin : g_out
      assign ext[i] = 1'b0;
    end
  end

  assign bit_o = ext[idx_i];
endmodule

// File: rtl/trap_target_core.sv
module trap_target_core
  import trap_sel_pkg::*;
#(
  parameter int CAUSE_W = 6,
  parameter int DELEG_W = 64
) (
  input  logic               is_intr_i,
  input  logic               is_nmi_i,
  input  priv_e              cur_priv_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [DELEG_W-1:0] mideleg_i,
  input  logic [DELEG_W-1:0] sideleg_i,
  input  logic [DELEG_W-1:0] medeleg_i,
  input  logic [DELEG_W-1:0] sedeleg_i,
  input  logic               has_s_i,
  input  logic               has_u_i,
  input  logic               has_n_i,
  output priv_e              tgt_o
);
  logic [DELEG_W-1:0] m_vec, s_vec;
  logic m_bit, s_bit, n_ok, lvl1, lvl2;

  assign m_vec = is_intr_i ? mideleg_i : medeleg_i;
  assign s_vec = is_intr_i ? sideleg_i : sedeleg_i;

  deleg_bit_pick #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_m_pick (
    .vec_i(m_vec), .idx_i(cause_i), .bit_o(m_bit)
  );
  deleg_bit_pick #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_s_pick (
    .vec_i(s_vec), .idx_i(cause_i), .bit_o(s_bit)
  );

  // User-level traps need user mode underneath them.
  assign n_ok = has_n_i & has_u_i;
  assign lvl1 = (cur_priv_i != PRIV_M) & m_bit;
  assign lvl2 = (cur_priv_i == PRIV_U) & has_s_i & n_ok & s_bit;

  always_comb begin
    tgt_o = PRIV_M;
    if (!is_nmi_i) begin
      if (lvl1) begin
        if (has_s_i)   tgt_o = PRIV_S;
        else if (n_ok) tgt_o = PRIV_U;
      end
      if (lvl2) tgt_o = PRIV_U;
    end
  end
endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_sel_pkg::*;
#(
  parameter int CAUSE_W = 6,
  parameter int DELEG_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               is_intr_i,
  input  logic               is_nmi_i,
  input  logic [1:0]         cur_priv_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [DELEG_W-1:0] mideleg_i,
  input  logic [DELEG_W-1:0] sideleg_i,
  input  logic [DELEG_W-1:0] medeleg_i,
  input  logic [DELEG_W-1:0] sedeleg_i,
  input  logic               has_s_i,
  input  logic               has_u_i,
  input  logic               has_n_i,
  output logic [1:0]         tgt_priv_o,
  output logic               tgt_valid_o
);
  priv_e tgt_d, tgt_q;

  trap_target_core #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_core (
    .is_intr_i (is_intr_i),
    .is_nmi_i  (is_nmi_i),
    .cur_priv_i(priv_e'(cur_priv_i)),
    .cause_i   (cause_i),
    .mideleg_i (mideleg_i),
    .sideleg_i (sideleg_i),
    .medeleg_i (medeleg_i),
    .sedeleg_i (sedeleg_i),
    .has_s_i   (has_s_i),
    .has_u_i   (has_u_i),
    .has_n_i   (has_n_i),
    .tgt_o     (tgt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q       <= PRIV_M;
      tgt_valid_o <= 1'b0;
    end else begin
      tgt_valid_o <= req_i;
      if (req_i) tgt_q <= tgt_d;
    end
  end

  assign tgt_priv_o = tgt_q;
endmodule

// File: rtl/trap_target_sel_chk.sv
module trap_target_sel_chk #(
  parameter int CAUSE_W = 6,
  parameter int DELEG_W = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               is_intr_i,
  input logic               is_nmi_i,
  input logic [1:0]         cur_priv_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [DELEG_W-1:0] mideleg_i,
  input logic [DELEG_W-1:0] medeleg_i,
  input logic               has_s_i,
  input logic               has_u_i,
  input logic               has_n_i,
  input logic [1:0]         tgt_priv_o,
  input logic               tgt_valid_o
);
  function automatic logic vbit(logic [DELEG_W-1:0] v, logic [CAUSE_W-1:0] c);
    logic r = 1'b0;
    for (int i = 0; i < DELEG_W; i++)
      if (i == int'(c)) r = v[i];
    return r;
  endfunction

  logic mb;
  assign mb = vbit(is_intr_i ? mideleg_i : medeleg_i, cause_i);

  a_in_priv_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> cur_priv_i != 2'b10);

  a_r2_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> tgt_valid_o);
  a_r2_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !tgt_valid_o);
  a_r3_nmi_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && is_nmi_i |=> tgt_priv_o == 2'b11);
  a_r4_from_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && cur_priv_i == 2'b11 |=> tgt_priv_o == 2'b11);
  a_r6_to_super: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !is_nmi_i && cur_priv_i == 2'b01 && has_s_i && mb
    |=> tgt_priv_o == 2'b01);
  a_r7_no_super: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !has_s_i |=> tgt_priv_o != 2'b01);
  a_r11_no_user_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !has_s_i && !(has_n_i && has_u_i) |=> tgt_priv_o == 2'b11);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(tgt_priv_o));
  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_priv_o != 2'b10);
endmodule

bind trap_target_sel trap_target_sel_chk #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .is_intr_i  (is_intr_i),
  .is_nmi_i   (is_nmi_i),
  .cur_priv_i (cur_priv_i),
  .cause_i    (cause_i),
  .mideleg_i  (mideleg_i),
  .medeleg_i  (medeleg_i),
  .has_s_i    (has_s_i),
  .has_u_i    (has_u_i),
  .has_n_i    (has_n_i),
  .tgt_priv_o (tgt_priv_o),
  .tgt_valid_o(tgt_valid_o)
);

// File: tb/sim_trap_target_sel.sv
`timescale 1ns/1ps
module sim_trap_target_sel;
  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, intr = 0, nmi = 0, hs = 0, hu = 0, hn = 0;
  logic [1:0]  cur = M;
  logic [5:0]  cause = '0;
  logic [63:0] mid = '0, sid = '0, med = '0, sed = '0;
  logic [1:0]  tgt, tgt1;
  logic        vld, vld1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_target_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .is_intr_i(intr), .is_nmi_i(nmi),
    .cur_priv_i(cur), .cause_i(cause), .mideleg_i(mid), .sideleg_i(sid),
    .medeleg_i(med), .sedeleg_i(sed), .has_s_i(hs), .has_u_i(hu), .has_n_i(hn),
    .tgt_priv_o(tgt), .tgt_valid_o(vld)
  );

  trap_target_sel #(.CAUSE_W(6), .DELEG_W(16)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .is_intr_i(intr), .is_nmi_i(nmi),
    .cur_priv_i(cur), .cause_i(cause), .mideleg_i(mid[15:0]), .sideleg_i(sid[15:0]),
    .medeleg_i(med[15:0]), .sedeleg_i(sed[15:0]), .has_s_i(hs), .has_u_i(hu),
    .has_n_i(hn), .tgt_priv_o(tgt1), .tgt_valid_o(vld1)
  );

  task automatic chk(string r, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", r, act, exp);
    end
  endtask

  // One request; result sampled at the falling edge after the capturing edge.
  task automatic fire(string r, logic [1:0] exp);
    @(negedge clk);
    req = 1;
    @(negedge clk);
    req = 0;
    chk({r, " valid"}, {1'b0, vld}, 2'b01);
    chk(r, tgt, exp);
  endtask

  task automatic setup(logic i, logic n, logic [1:0] c, logic [5:0] k,
                       logic s, logic u, logic nn);
    intr = i; nmi = n; cur = c; cause = k; hs = s; hu = u; hn = nn;
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {1'b0, vld}, 2'b00);
    chk("R1 reset priv", tgt, M);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", tgt, M);
  endtask

  task automatic t_nmi;
    mid = '1; sid = '1; med = '1; sed = '1;
    setup(1, 1, U, 6'd3, 1, 1, 1);
    fire("R3 nmi from U", M);
    setup(0, 1, S, 6'd7, 1, 1, 1);
    fire("R3 nmi exception path", M);
  endtask

  task automatic t_from_m;
    mid = '1; med = '1;
    setup(1, 0, M, 6'd5, 1, 1, 1);
    fire("R4 from machine", M);
  endtask

  task automatic t_no_deleg;
    mid = '1; mid[9] = 0; sid = '0; med = '0; sed = '0;
    setup(1, 0, S, 6'd9, 1, 1, 1);
    fire("R5 bit clear", M);
  endtask

  task automatic t_s_deleg;
    mid = '0; mid[9] = 1; sid = '0;
    setup(1, 0, S, 6'd9, 1, 1, 1);
    fire("R6 to S from S", S);
    setup(1, 0, U, 6'd9, 1, 1, 1);
    fire("R6 to S from U", S);
  endtask

  task automatic t_fallback;
    mid = '0; mid[11] = 1; sid = '0;
    setup(1, 0, U, 6'd11, 0, 1, 1);
    fire("R7 no S with N gives U", U);
    setup(1, 0, U, 6'd11, 0, 1, 0);
    fire("R7 no S no N gives M", M);
  endtask

  task automatic t_second;
    mid = '0; mid[4] = 1; sid = '0; sid[4] = 1;
    setup(1, 0, U, 6'd4, 1, 1, 1);
    fire("R8 second level to U", U);
    setup(1, 0, U, 6'd4, 1, 1, 0);
    fire("R8 needs N stays S", S);
    setup(1, 0, S, 6'd4, 1, 1, 1);
    fire("R8 not from S", S);
    mid = '0;
    setup(1, 0, U, 6'd4, 1, 1, 1);
    fire("R8 without machine bit", U);
  endtask

  task automatic t_pair;
    mid = '0; sid = '0; med = '0; sed = '0;
    med[2] = 1;
    setup(1, 0, S, 6'd2, 1, 1, 1);
    fire("R9 intr ignores medeleg", M);
    setup(0, 0, S, 6'd2, 1, 1, 1);
    fire("R9 exception uses medeleg", S);
    med = '0; mid[2] = 1;
    fire("R9 exception ignores mideleg", M);
    med[2] = 1; sed[2] = 1; mid = '0;
    setup(0, 0, U, 6'd2, 1, 1, 1);
    fire("R9 exception uses sedeleg", U);
  endtask

  task automatic t_n_needs_u;
    mid = '0; mid[6] = 1; sid = '0; sid[6] = 1;
    setup(1, 0, U, 6'd6, 0, 0, 1);
    fire("R11 N without U", M);
    setup(1, 0, U, 6'd6, 1, 0, 1);
    fire("R11 no second level without U", S);
  endtask

  task automatic t_range;
    mid = '1; sid = '0; med = '1; sed = '0;
    setup(1, 0, S, 6'd20, 1, 1, 1);
    fire("R10 wide in range", S);
    chk("R10 narrow out of range", tgt1, M);
    setup(0, 0, S, 6'd63, 1, 1, 1);
    fire("R10 wide exc in range", S);
    chk("R10 narrow exc out of range", tgt1, M);
  endtask

  task automatic t_hold;
    mid = '0; mid[1] = 1;
    setup(1, 0, S, 6'd1, 1, 1, 1);
    fire("R12 set S", S);
    setup(1, 1, M, 6'd0, 0, 0, 0);
    @(negedge clk);
    chk("R2 no valid when idle", {1'b0, vld}, 2'b00);
    chk("R12 held", tgt, S);
    repeat (3) @(negedge clk);
    chk("R12 still held", tgt, S);
    @(negedge clk); req = 1;
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    chk("R2 back-to-back valid", {1'b0, vld}, 2'b01);
    @(negedge clk);
    chk("R2 single pulse", {1'b0, vld}, 2'b00);
    chk("R3 result after burst", tgt, M);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_nmi;
    t_from_m;
    t_no_deleg;
    t_s_deleg;
    t_fallback;
    t_second;
    t_pair;
    t_n_needs_u;
    t_range;
    t_hold;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule